// File: doc/BRIEF.md
# Routed Level-Sensitive Interrupt Controller

This block collects nine level-sensitive interrupt inputs and presents them on three request lines toward a host interrupt controller. Each input passes through a two-flop synchroniser and then through a polarity stage, which decides whether a high or a low level counts as a request. A request sets a pending flag for that source. The flag stays set until software clears it, and it sets again while the source is still asserting.

Every request line has a control word of its own. The low half of the word holds one enable per source. The upper half shows the shared pending vector and takes write-one-to-clear acknowledges. A source reaches a line when that line's word enables it. A source enabled in two words drives both lines. Software reaches the block through a flat 32-bit register port: a word-aligned byte address, a write strobe and a combinational read path.

Top module: `lir_ctrl`

## Requirements
- R1: After reset every enable and every pending flag is 0. The polarity word at offset 0x0 reads 0x102: sources 1 and 8 are hard-wired active-high, and the rest read active-low. All three request lines are low.
- R2: In the polarity word, bit k holds the polarity of source k (1 = active-high, 0 = active-low). Writes update only the programmable sources 0 and 3..7. Bits 1 and 8 always read 1, bit 2 always reads 0, and bits 31:9 read 0.
- R3: The control word for line n sits at byte offset 0x4 + 4*n (0x4, 0x8, 0xC). Bits [8:0] are enables, with bit k enabling source k on that line. A write loads them and a read returns them.
- R4: A pending flag sets when the synchronised input of its source, after polarity, is asserted. Bit 16+k of every line word shows the flag of source k, whether or not that line enables it.
- R5: Writing 1 to bit 16+k of any line word clears the flag of source k on that write's clock edge. Writing 0 there leaves the flag unchanged. If the source is still asserted, the flag sets again on the next edge.
- R6: Request line n is high exactly while some source is both pending and enabled in line n's word. Clearing an enable masks the source without clearing its flag.
- R7: An input level change first shows in the pending flag, and so on a request line, after the third rising clock edge that follows it.
- R8: Offsets 0x10 to 0x1C read 0, and writes to them change nothing. Bits 15:9 and 31:25 of the line words read 0 and ignore writes.
- R9: A programmable source set active-high raises its flag while its input is high. Set active-low, it raises the flag while its input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 9 | Raw level interrupt inputs, one per source |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_line | output | 3 | Request lines toward the host controller, active high |

## Verification
The bench goes after four corner cases.

- An acknowledge that arrives while the source still asserts must let the flag drop for exactly one cycle. A design that gives the set priority never shows the drop, and one that forgets the re-set leaves a live request unseen.
- The synchroniser latency is checked at the exact edges. A missing or extra stage moves the line by one cycle.
- Writes of ones to the hard-wired polarity bits must not move them, and writes to unmapped offsets must not alias into the line words. A decoder that aliases would change enables or clear flags.
- Masking must leave the flag set. An enable that gates the flag itself would lose the request once the line is enabled again.

// File: rtl/lir_pkg.sv
package lir_pkg;

   // Bit position where the pending/acknowledge field starts in a line word.
   localparam int LIR_PEND_LSB = 16;

   typedef enum logic [1:0] {
      RK_CFG  = 2'd0,
      RK_LINE = 2'd1,
      RK_NONE = 2'd2
   } lir_region_e;

endpackage

// File: rtl/lir_sync.sv
module lir_sync #(
   parameter int            W       = 9,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/lir_polarity.sv
module lir_polarity #(
   parameter int                N_SRC    = 9,
   parameter logic [N_SRC-1:0]  FIXED_HI = 9'h102,
   parameter logic [N_SRC-1:0]  FIXED_LO = 9'h004
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [N_SRC-1:0] wdata_i,
   input  logic [N_SRC-1:0] lvl_i,
   output logic [N_SRC-1:0] pol_o,
   output logic [N_SRC-1:0] active_o
);

   localparam logic [N_SRC-1:0] PROG = ~(FIXED_HI | FIXED_LO);

   for (genvar k = 0; k < N_SRC; k++) begin : g_bit
      if (FIXED_HI[k]) begin : g_hi
         assign pol_o[k] = 1'b1;
      end else if (FIXED_LO[k]) begin : g_lo
         assign pol_o[k] = 1'b0;
      end else begin : g_prog
         logic pol_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    pol_q <= 1'b0;
            else if (we_i) pol_q <= wdata_i[k];
         end
         assign pol_o[k] = pol_q;
      end
   end

   // A source asserts when its level equals its polarity bit.
   assign active_o = ~(lvl_i ^ pol_o);

   // R2: programmable polarity bits take the written value
   a_r2_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> ((pol_o & PROG) == ($past(wdata_i) & PROG)));

   // R2: programmable polarity bits hold without a write
   a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> ((pol_o & PROG) == ($past(pol_o) & PROG)));

endmodule

// File: rtl/lir_pend_bank.sv
module lir_pend_bank #(
   parameter int N_SRC = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] active_i,
   input  logic [N_SRC-1:0] ack_i,
   output logic [N_SRC-1:0] pend_o
);

   logic [N_SRC-1:0] pend_q;

   // An acknowledge wins for one edge; a live source re-sets on the next.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q | active_i) & ~ack_i;
   end

   assign pend_o = pend_q;

   // R5: acknowledged flags are clear after the write edge
   a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i != '0) |=> ((pend_q & $past(ack_i)) == '0));

   // R4: an asserted, unacknowledged source is pending after the edge
   a_r4_sets_on_active: assert property (@(posedge clk) disable iff (!rst_n)
      ((active_i & ~ack_i) != '0) |=>
         ((pend_q & $past(active_i & ~ack_i)) == $past(active_i & ~ack_i)));

   // R4: a flag never rises without its source asserting
   a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((pend_q & ~$past(pend_q) & ~$past(active_i)) == '0));

endmodule

// File: rtl/lir_line_gate.sv
module lir_line_gate #(
   parameter int N_SRC = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [N_SRC-1:0] wdata_i,
   input  logic [N_SRC-1:0] pend_i,
   output logic [N_SRC-1:0] en_o,
   output logic             irq_o
);

   logic [N_SRC-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_q <= '0;
      else if (we_i) en_q <= wdata_i;
   end

   assign en_o  = en_q;
   assign irq_o = |(en_q & pend_i);

   // R3: an enable write is visible on the next cycle
   a_r3_en_load: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (en_o == $past(wdata_i)));

   // R6: a raised line always has some pending source behind it
   a_r6_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (pend_i != '0));

   // R6: a line with every source masked stays low
   a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (en_o == '0) |-> !irq_o);

endmodule

// File: rtl/lir_ctrl.sv
module lir_ctrl
   import lir_pkg::*;
#(
   parameter int                N_SRC       = 9,
   parameter int                N_LINE      = 3,
   parameter int                ADDR_W      = 5,
   parameter int                DATA_W      = 32,
   parameter int                SYNC_STAGES = 2,
   parameter logic [N_SRC-1:0]  FIXED_HI    = 9'h102,
   parameter logic [N_SRC-1:0]  FIXED_LO    = 9'h004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_in,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_LINE-1:0] irq_line
);

   localparam int               IDX_W    = ADDR_W - 2;
   localparam logic [N_SRC-1:0] SYNC_RST = ~FIXED_HI;

   // ---------------- elaboration checks ----------------
   if (N_SRC < 1 || N_SRC >= LIR_PEND_LSB) begin : g_chk_nsrc
      $error("lir_ctrl: N_SRC out of range");
   end
   if (DATA_W <= LIR_PEND_LSB + N_SRC) begin : g_chk_data
      $error("lir_ctrl: DATA_W too narrow for pending field");
   end
   if ((FIXED_HI & FIXED_LO) != '0) begin : g_chk_fixed
      $error("lir_ctrl: a source cannot be fixed both high and low");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("lir_ctrl: at least two synchroniser stages required");
   end
   if (IDX_W < 1 || (N_LINE + 1) > (1 << IDX_W)) begin : g_chk_addr
      $error("lir_ctrl: address space too small for line words");
   end

   // ---------------- address decode ----------------
   logic [IDX_W-1:0] widx;
   logic [IDX_W-1:0] lidx;
   lir_region_e      region;
   logic             wr_cyc;
   logic             cfg_we;
   logic [N_LINE-1:0] line_we;
   logic [N_SRC-1:0] ack;

   assign widx   = bus_addr[ADDR_W-1:2];
   assign lidx   = widx - IDX_W'(1);
   assign wr_cyc = bus_sel & bus_wr;

   always_comb begin
      if (widx == '0)                   region = RK_CFG;
      else if (widx <= IDX_W'(N_LINE))  region = RK_LINE;
      else                              region = RK_NONE;
   end

   assign cfg_we = wr_cyc && (region == RK_CFG);
   assign ack    = (wr_cyc && (region == RK_LINE)) ?
                   bus_wdata[LIR_PEND_LSB +: N_SRC] : '0;

   for (genvar n = 0; n < N_LINE; n++) begin : g_we
      assign line_we[n] = wr_cyc && (region == RK_LINE) && (lidx == IDX_W'(n));
   end

   // ---------------- datapath ----------------
   logic [N_SRC-1:0] sync_q;
   logic [N_SRC-1:0] pol;
   logic [N_SRC-1:0] active;
   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] en_all [N_LINE];

   lir_sync #(
      .W       (N_SRC),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (irq_in),
      .q_o   (sync_q)
   );

   lir_polarity #(
      .N_SRC    (N_SRC),
      .FIXED_HI (FIXED_HI),
      .FIXED_LO (FIXED_LO)
   ) u_pol (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (cfg_we),
      .wdata_i  (bus_wdata[N_SRC-1:0]),
      .lvl_i    (sync_q),
      .pol_o    (pol),
      .active_o (active)
   );

   lir_pend_bank #(
      .N_SRC (N_SRC)
   ) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .ack_i    (ack),
      .pend_o   (pend)
   );

   for (genvar n = 0; n < N_LINE; n++) begin : g_line
      lir_line_gate #(
         .N_SRC (N_SRC)
      ) u_line (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_i    (line_we[n]),
         .wdata_i (bus_wdata[N_SRC-1:0]),
         .pend_i  (pend),
         .en_o    (en_all[n]),
         .irq_o   (irq_line[n])
      );
   end

   // ---------------- read path ----------------
   always_comb begin
      bus_rdata = '0;
      case (region)
         RK_CFG: bus_rdata[N_SRC-1:0] = pol;
         RK_LINE: begin
            for (int n = 0; n < N_LINE; n++) begin
               if (lidx == IDX_W'(n)) bus_rdata[N_SRC-1:0] = en_all[n];
            end
            bus_rdata[LIR_PEND_LSB +: N_SRC] = pend;
         end
         default: bus_rdata = '0;
      endcase
   end

   logic unused_bus_bits;
   assign unused_bus_bits = ^{bus_addr[1:0],
                              bus_wdata[DATA_W-1:LIR_PEND_LSB+N_SRC],
                              bus_wdata[LIR_PEND_LSB-1:N_SRC]};

   // R8: writes to unmapped offsets leave polarity and flags alone
   a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cyc && (region == RK_NONE)) |=> ($stable(pol) && ((pend & ~$past(pend)) == (pend & ~$past(pend) & $past(active)))));

endmodule

// File: tb/lir_ctrl_test.sv
`timescale 1ns/1ps
module lir_ctrl_test;

   localparam logic [8:0] FH   = 9'h102;
   localparam logic [8:0] FL   = 9'h004;
   localparam logic [8:0] PROG = ~(FH | FL);
   localparam logic [8:0] IDLE = ~FH;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  irq_in = IDLE;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq_line;

   int total = 0;
   int bad   = 0;
   bit running = 1'b0;

   always #10 clk = ~clk;

   lir_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_line  (irq_line)
   );

   // ---------------- behavioural reference ----------------
   logic [8:0] m_pol, m_pend, m_s1, m_s2, m_act, m_ack;
   logic [8:0] m_en [3];
   int         m_idx;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pol = FH; m_pend = '0; m_s1 = IDLE; m_s2 = IDLE;
         for (int n = 0; n < 3; n++) m_en[n] = '0;
      end else begin
         m_idx = int'(bus_addr[4:2]);
         m_ack = '0;
         m_act = ~(m_s2 ^ m_pol);
         if (bus_sel && bus_wr) begin
            if (m_idx == 0) m_pol = (bus_wdata[8:0] & PROG) | FH;
            else if (m_idx <= 3) begin
               m_en[m_idx-1] = bus_wdata[8:0];
               m_ack = bus_wdata[24:16];
            end
         end
         m_pend = (m_pend | m_act) & ~m_ack;
         m_s2 = m_s1;
         m_s1 = irq_in;
      end
   end

   function automatic logic [31:0] exp_read(input logic [4:0] a);
      int idx;
      idx = int'(a[4:2]);
      if (idx == 0)      return {23'd0, m_pol};
      else if (idx <= 3) return {7'd0, m_pend, 7'd0, m_en[idx-1]};
      else               return 32'd0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // R6: every cycle, each line against the reference
   always @(negedge clk) begin
      if (rst_n && running) begin
         for (int n = 0; n < 3; n++)
            check("R6 line", {31'd0, irq_line[n]}, {31'd0, |(m_pend & m_en[n])});
      end
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_exp(input logic [4:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2;
      check(tag, bus_rdata, e);
      check({tag, " model"}, bus_rdata, exp_read(a));
   endtask

   task automatic rd(input logic [4:0] a, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2;
      check(tag, bus_rdata, exp_read(a));
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         bus_sel = 1'b0; bus_wr = 1'b0;
      end
   endtask

   task automatic set_in(input logic [8:0] v);
      @(negedge clk);
      irq_in = v;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      running = 1'b1;

      // R1: reset state
      #2;
      check("R1 lines", {29'd0, irq_line}, 32'd0);
      rd_exp(5'h00, 32'h0000_0102, "R1 polarity");
      rd_exp(5'h04, 32'h0, "R1 line0");
      rd_exp(5'h08, 32'h0, "R1 line1");
      rd_exp(5'h0C, 32'h0, "R1 line2");

      // R2: programmable polarity bits only
      wr(5'h00, 32'hFFFF_FFFF);
      rd_exp(5'h00, 32'h0000_01FB, "R2 fixed bits hold");
      wr(5'h00, 32'h0000_0000);
      rd_exp(5'h00, 32'h0000_0102, "R2 cleared");
      wr(5'h04, 32'h01FF_0000);
      idle(4);
      rd_exp(5'h04, 32'h0, "R5 ack all");

      // R3 / R8: enables and unused bits
      wr(5'h04, 32'h0000_0001);
      wr(5'h08, 32'h0000_0106);
      wr(5'h0C, 32'hFE00_FEF8);
      rd_exp(5'h0C, 32'h0000_00F8, "R3 R8 line2 enables");
      rd_exp(5'h04, 32'h0000_0001, "R3 line0 enables");
      idle(1);

      // R7 / R9: source 0 active-low, latency of three edges
      set_in(IDLE & ~9'h001);
      @(negedge clk);
      @(negedge clk); #2;
      check("R7 not yet", {31'd0, irq_line[0]}, 32'd0);
      @(negedge clk); #2;
      check("R7 third edge", {31'd0, irq_line[0]}, 32'd1);
      // R4: visible in a line that does not enable it
      rd_exp(5'h08, 32'h0001_0106, "R4 pending shown");

      // R5: ack while still asserted re-sets next cycle
      wr(5'h04, 32'h0001_0001);
      #2;
      check("R5 cleared", {31'd0, irq_line[0]}, 32'd0);
      @(negedge clk); #2;
      check("R5 re-set", {31'd0, irq_line[0]}, 32'd1);
      set_in(IDLE);
      idle(4);
      wr(5'h04, 32'h0001_0001);
      idle(2);
      rd_exp(5'h04, 32'h0000_0001, "R5 clear stays");

      // R5: zero in ack bits leaves flag; R8 unmapped
      set_in(IDLE | 9'h100);
      idle(4);
      set_in(IDLE);
      idle(4);
      rd_exp(5'h08, 32'h0100_0106, "R4 src8 latched");
      wr(5'h08, 32'h0000_0106);
      rd_exp(5'h08, 32'h0100_0106, "R5 zero no effect");
      wr(5'h10, 32'hFFFF_FFFF);
      wr(5'h1C, 32'hFFFF_FFFF);
      rd_exp(5'h10, 32'h0, "R8 unmapped 0x10");
      rd_exp(5'h1C, 32'h0, "R8 unmapped 0x1C");
      rd_exp(5'h08, 32'h0100_0106, "R8 line1 untouched");
      rd_exp(5'h00, 32'h0000_0102, "R8 polarity untouched");
      wr(5'h0C, 32'h0100_00F8);
      rd_exp(5'h08, 32'h0000_0106, "R5 ack via other line");

      // R9: source 3 active-high
      wr(5'h00, 32'h0000_0008);
      idle(2);
      #2;
      check("R9 active-high raises", {31'd0, irq_line[2]}, 32'd1);
      set_in(IDLE & ~9'h008);
      idle(4);
      wr(5'h0C, 32'h0008_00F8);
      idle(2);
      #2;
      check("R9 low input idle", {31'd0, irq_line[2]}, 32'd0);
      rd_exp(5'h0C, 32'h0000_00F8, "R9 flag stays clear");

      // R6: masking keeps the flag
      set_in(IDLE & ~9'h004);
      idle(4);
      wr(5'h08, 32'h0000_0000);
      #2;
      check("R6 masked line low", {31'd0, irq_line[1]}, 32'd0);
      rd(5'h08, "R6 flag kept");
      wr(5'h08, 32'h0000_0004);
      #2;
      check("R6 unmask restores", {31'd0, irq_line[1]}, 32'd1);

      // mixed traffic against the reference
      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (lfsr[2:0])
            3'd0: wr({lfsr[5:3], 2'b00}, {7'd0, lfsr[12:4], 7'd0, lfsr[15:7]});
            3'd1: rd({lfsr[5:3], 2'b00}, "R4 mixed read");
            3'd2: wr(5'h00, {23'd0, lfsr[13:5]});
            default: set_in(lfsr[14:6]);
         endcase
      end
      for (int a = 0; a < 8; a++) rd(5'(a * 4), "R3 final read");
      idle(4);
      running = 1'b0;
      finish_run();
   end

endmodule